// File: doc/BRIEF.md
# Periodic Neuron Relaxation Scheduler

This block gives a crossbar of spiking neuron circuits a regular rest. A free-running interval timer opens a relaxation window every `interval_cyc` cycles. While the window is open the crossbar is told to relax (`destress_active`), and no spike may leave the block. The window lasts `window_cyc` cycles. A recharge period of `recharge_cyc` cycles follows, during which the neurons return to their operating level and still may not fire. Spike requests that arrive while firing is blocked are held in a pending queue. They are released one per cycle once recharge is over, so the latency of a held spike grows by up to the window plus the recharge time.

The block also tracks two aging figures. The recoverable stress value rises on every cycle in which a spike is propagated. It decays slowly on idle cycles and quickly inside a relaxation window. The permanent stress value never falls: it grows fast on busy cycles and slowly on idle ones. A warning output rises when either figure reaches 1000. Two free-running counters report stalled cycles and held spikes, so that software can work out the overhead ratio.

The control is a four-state machine:
- RUN: spikes pass straight through. When the interval expires, the machine moves to DESTRESS.
- DESTRESS: the window is open. After `window_cyc` cycles the machine moves to RECHARGE.
- RECHARGE: firing stays blocked. After `recharge_cyc` cycles the machine moves to DRAIN if spikes are pending, and otherwise back to RUN.
- DRAIN: held spikes are released. The machine returns to RUN when the queue becomes empty. If the interval expires first, it goes straight to DESTRESS.

Top module: `destress_ctrl`

## Requirements
- R1: `destress_active` first rises `interval_cyc` cycles after reset is released, and then every `interval_cyc` cycles, since each interval starts counting when the previous window opens. It stays high for exactly `window_cyc` cycles.
- R2: A recharge period of `recharge_cyc` cycles follows each window. `spike_out` is never high during a window or a recharge period.
- R3: In RUN, a request that arrives in a cycle where the interval does not expire produces a one-cycle `spike_out` pulse on the next cycle.
- R4: A request made during DESTRESS, RECHARGE or DRAIN, or made in the RUN cycle where the interval expires, is held. Held spikes are released one per cycle in DRAIN, except in a cycle where the interval expires. A new request made in DRAIN joins the back of the queue.
- R5: The queue holds `QDEPTH` entries (default 4). A request that would be held while the queue is full is dropped, and `defer_overflow` then stays high until reset.
- R6: `rest_stress` changes once per cycle. Inside a window it falls by 4. Otherwise it rises by 3 when `spike_out` is high and falls by 1 when `spike_out` is low. It never goes below 0 and saturates at 4095.
- R7: `perm_stress` rises by 2 on each cycle where `spike_out` is high. It rises by 1 for every 8 cycles where `spike_out` is low. It never decreases and saturates at 4095.
- R8: `age_warn` is high exactly when either stress value is 1000 or more.
- R9: `stall_count` counts cycles spent in a window or a recharge period. `deferred_count` counts the requests accepted into the queue; dropped requests are not counted.
- R10: After reset, both outputs and both counters read 0, `defer_overflow` and `age_warn` are low, and the machine is in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| interval_cyc | input | CNT_W | Cycles from one window start to the next |
| window_cyc | input | CNT_W | Length of a relaxation window in cycles |
| recharge_cyc | input | CNT_W | Length of the recharge period in cycles |
| spike_req | input | 1 | Spike request, one per cycle |
| spike_out | output | 1 | Spike issued to the crossbar |
| destress_active | output | 1 | Relaxation window open |
| rest_stress | output | AGE_W | Recoverable stress value |
| perm_stress | output | AGE_W | Permanent stress value |
| age_warn | output | 1 | A stress value has reached the limit |
| defer_overflow | output | 1 | Sticky flag: a held request was dropped |
| stall_count | output | CTR_W | Cycles spent in window or recharge |
| deferred_count | output | CTR_W | Requests accepted into the queue |

## Verification
The assertions assume that the three timing inputs are at least 1, that they change only while reset is held, and that `interval_cyc` is larger than `window_cyc + recharge_cyc + QDEPTH + 2`. Under these conditions an interval can only expire in RUN or DRAIN. The bench sets the timing values only inside a reset pulse and picks three sets that meet the bound. It then drives sparse, continuous and absent request streams, which cover draining, overflow, the warning limit and slow idle aging.

// File: rtl/destress_pkg.sv
package destress_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_DESTRESS = 2'd1,
        ST_RECHARGE = 2'd2,
        ST_DRAIN    = 2'd3
    } dstate_t;
endpackage

// File: rtl/destress_fsm.sv
module destress_fsm
    import destress_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval_cyc,
    input  logic [CNT_W-1:0] window_cyc,
    input  logic [CNT_W-1:0] recharge_cyc,
    input  logic             q_empty_next,
    output dstate_t          state,
    output logic             expire,
    output logic             relax,
    output logic             stalled
);
    dstate_t          nxt;
    logic [CNT_W-1:0] ival;
    logic [CNT_W-1:0] win;
    logic [CNT_W-1:0] win_nxt;

    assign expire = (ival == interval_cyc - CNT_W'(1));

    // next-state and window counter logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (expire) nxt = ST_DESTRESS;
            ST_DESTRESS: if (win == window_cyc - CNT_W'(1)) nxt = ST_RECHARGE;
            ST_RECHARGE: if (win == recharge_cyc - CNT_W'(1))
                             nxt = q_empty_next ? ST_RUN : ST_DRAIN;
            ST_DRAIN: begin
                if (expire)            nxt = ST_DESTRESS;
                else if (q_empty_next) nxt = ST_RUN;
            end
        endcase
        if (nxt != state)
            win_nxt = '0;
        else if (state == ST_DESTRESS || state == ST_RECHARGE)
            win_nxt = win + CNT_W'(1);
        else
            win_nxt = '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            ival  <= '0;
            win   <= '0;
        end else begin
            state <= nxt;
            ival  <= expire ? '0 : ival + CNT_W'(1);
            win   <= win_nxt;
        end
    end

    // outputs
    always_comb begin
        relax   = 1'b0;
        stalled = 1'b0;
        unique case (state)
            ST_DESTRESS: begin relax = 1'b1; stalled = 1'b1; end
            ST_RECHARGE: stalled = 1'b1;
            default: ;
        endcase
    end

    assert_window_on_expiry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(relax) |-> $past(expire));
    assert_recharge_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(relax) |-> state == ST_RECHARGE);
endmodule

// File: rtl/pend_queue.sv
module pend_queue #(
    parameter int QDEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_req,
    input  logic pop,
    output logic accept,
    output logic nonempty,
    output logic empty_next,
    output logic overflow
);
    localparam int LVL_W = $clog2(QDEPTH + 1);

    logic [LVL_W-1:0] level;
    logic [LVL_W-1:0] level_nxt;
    logic             full;

    assign full       = (level == LVL_W'(QDEPTH));
    assign accept     = push_req && !full;
    assign nonempty   = (level != '0);
    assign level_nxt  = level + LVL_W'(accept) - LVL_W'(pop);
    assign empty_next = (level_nxt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level    <= '0;
            overflow <= 1'b0;
        end else begin
            level <= level_nxt;
            if (push_req && full) overflow <= 1'b1;
        end
    end

    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> level != '0);
    assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/aging_track.sv
module aging_track #(
    parameter int AGE_W         = 12,
    parameter int BUSY_STEP     = 3,
    parameter int IDLE_STEP     = 1,
    parameter int RELAX_STEP    = 4,
    parameter int PERM_BUSY     = 2,
    parameter int PERM_IDLE_DIV = 8,
    parameter int WARN_LEVEL    = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             relax,
    output logic [AGE_W-1:0] rest_stress,
    output logic [AGE_W-1:0] perm_stress,
    output logic             age_warn
);
    localparam int DIV_W = (PERM_IDLE_DIV > 1) ? $clog2(PERM_IDLE_DIV) : 1;
    localparam logic [AGE_W:0] AMAX = {1'b0, {AGE_W{1'b1}}};

    logic [AGE_W:0]   rest_sum;
    logic [AGE_W:0]   perm_sum;
    logic [AGE_W-1:0] rest_nxt;
    logic [DIV_W-1:0] div;
    logic             div_wrap;

    assign div_wrap = (div == DIV_W'(PERM_IDLE_DIV - 1));
    assign rest_sum = {1'b0, rest_stress} + (AGE_W+1)'(BUSY_STEP);
    assign perm_sum = {1'b0, perm_stress} +
                      (busy ? (AGE_W+1)'(PERM_BUSY) : (AGE_W+1)'(div_wrap));

    always_comb begin
        if (relax)
            rest_nxt = (rest_stress >= AGE_W'(RELAX_STEP)) ? rest_stress - AGE_W'(RELAX_STEP) : '0;
        else if (busy)
            rest_nxt = (rest_sum > AMAX) ? AMAX[AGE_W-1:0] : rest_sum[AGE_W-1:0];
        else
            rest_nxt = (rest_stress >= AGE_W'(IDLE_STEP)) ? rest_stress - AGE_W'(IDLE_STEP) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rest_stress <= '0;
            perm_stress <= '0;
            div         <= '0;
        end else begin
            rest_stress <= rest_nxt;
            perm_stress <= (perm_sum > AMAX) ? AMAX[AGE_W-1:0] : perm_sum[AGE_W-1:0];
            if (!busy) div <= div_wrap ? '0 : div + DIV_W'(1);
        end
    end

    assign age_warn = (rest_stress >= AGE_W'(WARN_LEVEL)) || (perm_stress >= AGE_W'(WARN_LEVEL));

    assert_rest_falls_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        relax |=> rest_stress <= $past(rest_stress));
    assert_perm_grows_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (perm_stress > $past(perm_stress)) || (perm_stress == AMAX[AGE_W-1:0]));
    assert_perm_never_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> perm_stress >= $past(perm_stress));
endmodule

// File: rtl/destress_ctrl.sv
module destress_ctrl
    import destress_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int AGE_W  = 12,
    parameter int CTR_W  = 32,
    parameter int QDEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval_cyc,
    input  logic [CNT_W-1:0] window_cyc,
    input  logic [CNT_W-1:0] recharge_cyc,
    input  logic             spike_req,
    output logic             spike_out,
    output logic             destress_active,
    output logic [AGE_W-1:0] rest_stress,
    output logic [AGE_W-1:0] perm_stress,
    output logic             age_warn,
    output logic             defer_overflow,
    output logic [CTR_W-1:0] stall_count,
    output logic [CTR_W-1:0] deferred_count
);
    dstate_t state;
    logic    expire, stalled, relax;
    logic    issue_now, hold_req, pop, accept, nonempty, empty_next;

    assign issue_now = (state == ST_RUN) && spike_req && !expire;
    assign hold_req  = spike_req && !issue_now;
    assign pop       = (state == ST_DRAIN) && !expire && nonempty;

    destress_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .interval_cyc(interval_cyc), .window_cyc(window_cyc), .recharge_cyc(recharge_cyc),
        .q_empty_next(empty_next),
        .state(state), .expire(expire), .relax(relax), .stalled(stalled)
    );

    pend_queue #(.QDEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_req(hold_req), .pop(pop),
        .accept(accept), .nonempty(nonempty), .empty_next(empty_next),
        .overflow(defer_overflow)
    );

    aging_track #(.AGE_W(AGE_W)) u_age (
        .clk(clk), .rst_n(rst_n),
        .busy(spike_out), .relax(relax),
        .rest_stress(rest_stress), .perm_stress(perm_stress), .age_warn(age_warn)
    );

    assign destress_active = relax;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spike_out      <= 1'b0;
            stall_count    <= '0;
            deferred_count <= '0;
        end else begin
            spike_out      <= issue_now || pop;
            stall_count    <= stall_count + CTR_W'(stalled);
            deferred_count <= deferred_count + CTR_W'(accept);
        end
    end

    assert_no_spike_while_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> !spike_out);
    assert_direct_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_now |=> spike_out);
endmodule

// File: tb/destress_ctrl_test.sv
`timescale 1ns/100ps
module destress_ctrl_test;
    localparam int DEPTH = 4;
    localparam int AMAXI = 4095;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] interval_cyc = 16'd40;
    logic [15:0] window_cyc = 16'd6;
    logic [15:0] recharge_cyc = 16'd3;
    logic        spike_req = 1'b0;
    logic        spike_out, destress_active, age_warn, defer_overflow;
    logic [11:0] rest_stress, perm_stress;
    logic [31:0] stall_count, deferred_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    destress_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .interval_cyc(interval_cyc), .window_cyc(window_cyc), .recharge_cyc(recharge_cyc),
        .spike_req(spike_req), .spike_out(spike_out), .destress_active(destress_active),
        .rest_stress(rest_stress), .perm_stress(perm_stress), .age_warn(age_warn),
        .defer_overflow(defer_overflow), .stall_count(stall_count), .deferred_count(deferred_count)
    );

    // behavioural reference: phase 0 run, 1 relax, 2 recharge, 3 drain
    int m_ph, m_ival, m_win, m_q, m_rest, m_perm, m_div, m_stall, m_defer;
    bit m_sp, m_ovf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_ival = 0; m_win = 0; m_q = 0; m_rest = 0; m_perm = 0;
            m_div = 0; m_stall = 0; m_defer = 0; m_sp = 0; m_ovf = 0;
        end else begin
            bit exp_now, iss, pp, pushed;
            int nph;
            exp_now = (m_ival == int'(interval_cyc) - 1);
            if (m_ph == 1)   m_rest = (m_rest >= 4) ? m_rest - 4 : 0;
            else if (m_sp)   m_rest = (m_rest + 3 > AMAXI) ? AMAXI : m_rest + 3;
            else             m_rest = (m_rest >= 1) ? m_rest - 1 : 0;
            if (m_sp) m_perm = (m_perm + 2 > AMAXI) ? AMAXI : m_perm + 2;
            else if (m_div == 7) begin m_div = 0; m_perm = (m_perm + 1 > AMAXI) ? AMAXI : m_perm + 1; end
            else m_div++;
            if (m_ph == 1 || m_ph == 2) m_stall++;
            iss = (m_ph == 0) && spike_req && !exp_now;
            pp  = (m_ph == 3) && !exp_now && (m_q > 0);
            pushed = 0;
            if (spike_req && !iss) begin
                if (m_q == DEPTH) m_ovf = 1;
                else begin pushed = 1; m_defer++; end
            end
            m_q = m_q + int'(pushed) - int'(pp);
            nph = m_ph;
            case (m_ph)
                0: if (exp_now) nph = 1;
                1: if (m_win == int'(window_cyc) - 1) nph = 2;
                2: if (m_win == int'(recharge_cyc) - 1) nph = (m_q == 0) ? 0 : 3;
                default: if (exp_now) nph = 1; else if (m_q == 0) nph = 0;
            endcase
            if (nph != m_ph) m_win = 0;
            else if (m_ph == 1 || m_ph == 2) m_win++;
            else m_win = 0;
            m_ph = nph;
            m_ival = exp_now ? 0 : m_ival + 1;
            m_sp = iss || pp;
        end
    end

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3/R4 spike_out", spike_out, m_sp);
        chk("R1/R2 destress_active", destress_active, m_ph == 1);
        chk("R6 rest_stress", rest_stress, m_rest);
        chk("R7 perm_stress", perm_stress, m_perm);
        chk("R8 age_warn", age_warn, (m_rest >= 1000) || (m_perm >= 1000));
        chk("R5 defer_overflow", defer_overflow, m_ovf);
        chk("R9 stall_count", stall_count, m_stall);
        chk("R9 deferred_count", deferred_count, m_defer);
    endtask

    task automatic do_reset(input int iv, input int wv, input int rv);
        @(negedge clk);
        rst_n = 1'b0;
        spike_req = 1'b0;
        interval_cyc = 16'(iv); window_cyc = 16'(wv); recharge_cyc = 16'(rv);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 spike_out", spike_out, 0);
        chk("R10 destress_active", destress_active, 0);
        chk("R10 rest_stress", rest_stress, 0);
        chk("R10 perm_stress", perm_stress, 0);
        chk("R10 flags", {age_warn, defer_overflow}, 0);
        chk("R10 counters", stall_count + deferred_count, 0);
        rst_n = 1'b1;
    endtask

    // mode 0 sparse, 1 continuous, 2 none
    task automatic run_phase(input int cycles, input int mode);
        logic [15:0] lfsr = 16'hACE1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare_all();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: spike_req = (lfsr[1:0] == 2'b00);
                1: spike_req = 1'b1;
                default: spike_req = 1'b0;
            endcase
        end
    endtask

    initial begin
        do_reset(40, 6, 3);
        run_phase(1500, 0);
        do_reset(60, 8, 4);
        run_phase(1500, 1);
        chk("R5 overflow reached", defer_overflow, 1);
        chk("R8 warn reached", age_warn, 1);
        do_reset(25, 3, 2);
        run_phase(400, 2);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule